// File: doc/BRIEF.md
# Single-Breakpoint Debug Run Controller

This block sits beside a processor's fetch stage and decides, cycle by cycle, whether the core may fetch. A debugger drives it through a small command port. The commands are run, stop, single step, core reset, set breakpoint and clear breakpoint. The controller raises `fetch_en` only when the core is allowed to fetch the instruction at `fetch_addr`. It reports whether the core is halted and why the last halt happened.

There is one breakpoint register, and each new address replaces the old one. The address is compared with the next fetch address before the fetch happens, so the instruction at the breakpoint has not executed when the core stops. The core reports each retired instruction and flags a retired software break instruction (ebreak). That flag halts the core whether or not the breakpoint is armed.

The controller has four states:
- `ST_HALT`: no fetch is allowed.
- `ST_RUN`: fetch is free, subject to the breakpoint.
- `ST_SFETCH`: the single cycle in which a step's instruction is fetched.
- `ST_SWAIT`: the step waits for that instruction to retire.

The transitions are:
- HALT→RUN on a run command.
- HALT→SFETCH on a step command.
- RUN→HALT on a reset command, an ebreak retire, a breakpoint hit or a stop command, in that priority order.
- SFETCH→SWAIT when nothing retires.
- SFETCH or SWAIT→HALT on a retire.

A command that arrives during a step is parked in a one-entry hold register. It is replayed in the first halted cycle after the step ends.

Top module: `dbg_runctl`

## Requirements
- R1: After `rst_n` is released, `halted`=1, `fetch_en`=0, `halt_cause`=0 (stop) and `core_rst`=0, and the breakpoint is disarmed. Whenever `halted`=1, `fetch_en` is 0.
- R2: A run command (`cmd_op`=1) accepted while halted clears `halted` and raises `fetch_en` from the next cycle. `fetch_en` stays high each cycle while no halt condition occurs.
- R3: A stop command (`cmd_op`=2) accepted while running sets `halted` in the next cycle with `halt_cause`=0. A stop while halted changes nothing.
- R4: A set-breakpoint command (`cmd_op`=5) arms the breakpoint at `cmd_addr` and replaces any earlier address. After that, a fetch at the earlier address no longer matches.
- R5: While running with the breakpoint armed, a cycle whose `fetch_addr` equals the breakpoint drives `fetch_en`=0 in that same cycle. The next cycle shows `halted`=1 with `halt_cause`=2 (breakpoint).
- R6: The first running cycle after a run command is never blocked by the breakpoint, so execution can leave a breakpoint address. A step's fetch is never blocked by the breakpoint either.
- R7: A clear-breakpoint command (`cmd_op`=6) disarms address matching. A retire with `retire_ebreak`=1 while running still halts the core in the next cycle with `halt_cause`=3 (ebreak).
- R8: A step command (`cmd_op`=3) gives exactly one cycle of `fetch_en`=1 and then holds `fetch_en`=0 until `retire`. The cycle after the retire shows `halted`=1 with `halt_cause`=1 (step), or `halt_cause`=3 when `retire_ebreak`=1.
- R9: A command presented while a step is in progress has no effect until the step's instruction retires. It is then applied from the first halted cycle, taking effect one cycle later.
- R10: A reset command (`cmd_op`=4) halts the core, sets `halt_cause`=0 and pulses `core_rst` for exactly one cycle, in the cycle after the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code: 0 none, 1 run, 2 stop, 3 step, 4 reset, 5 set breakpoint, 6 clear breakpoint |
| cmd_addr | input | AW | Breakpoint address for the set-breakpoint command |
| fetch_addr | input | AW | Address the core will fetch next |
| retire | input | 1 | An instruction retired this cycle |
| retire_ebreak | input | 1 | The retiring instruction is ebreak |
| fetch_en | output | 1 | Core may fetch `fetch_addr` this cycle |
| halted | output | 1 | Core is halted |
| halt_cause | output | 2 | Last halt reason: 0 stop/reset, 1 step, 2 breakpoint, 3 ebreak |
| core_rst | output | 1 | One-cycle request to zero the program counter and registers |

## Verification
Several properties are checked on every cycle:
- No fetch is granted while halted.
- No fetch is granted on an armed breakpoint address outside the first running cycle.
- A step grants exactly one fetch.
- An ebreak retire always lands in a halt with the ebreak cause.
- A core reset pulse only ever appears in a halted state with the stop cause.

Other behaviours can only be shown by the bench's scenarios: an older breakpoint address stops matching after replacement, and a run can leave a breakpoint address. The same holds for a command parked during a step reappearing as a run after the retire, and for the order in which halt causes are reported.

// File: rtl/dbg_rc_pkg.sv
package dbg_rc_pkg;
    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_RUN   = 3'd1,
        OP_STOP  = 3'd2,
        OP_STEP  = 3'd3,
        OP_RESET = 3'd4,
        OP_SETBP = 3'd5,
        OP_CLRBP = 3'd6
    } rc_op_e;

    typedef enum logic [1:0] {
        HC_STOP   = 2'd0,
        HC_STEP   = 2'd1,
        HC_BREAK  = 2'd2,
        HC_EBREAK = 2'd3
    } rc_cause_e;

    typedef enum logic [1:0] {
        ST_HALT   = 2'd0,
        ST_RUN    = 2'd1,
        ST_SFETCH = 2'd2,
        ST_SWAIT  = 2'd3
    } rc_state_e;
endpackage

// File: rtl/rc_bp_unit.sv
module rc_bp_unit #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_i,
    input  logic          clr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] fetch_addr_i,
    output logic          armed_o,
    output logic [AW-1:0] bp_addr_o,
    output logic          hit_o
);
    logic          armed_q;
    logic [AW-1:0] addr_q;

    // a new set simply overwrites the single slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            addr_q  <= '0;
        end else if (set_i) begin
            armed_q <= 1'b1;
            addr_q  <= addr_i;
        end else if (clr_i) begin
            armed_q <= 1'b0;
        end
    end

    assign armed_o   = armed_q;
    assign bp_addr_o = addr_q;
    assign hit_o     = armed_q && (fetch_addr_i == addr_q);
endmodule

// File: rtl/rc_cmd_hold.sv
module rc_cmd_hold #(
    parameter int AW = 32,
    parameter int OW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture_i,
    input  logic [OW-1:0] op_i,
    input  logic [AW-1:0] addr_i,
    input  logic          release_i,
    output logic          vld_o,
    output logic [OW-1:0] op_o,
    output logic [AW-1:0] addr_o
);
    logic          vld_q;
    logic [OW-1:0] op_q;
    logic [AW-1:0] addr_q;

    // capture wins over release so a command in the replay cycle is kept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            op_q   <= '0;
            addr_q <= '0;
        end else if (capture_i) begin
            vld_q  <= 1'b1;
            op_q   <= op_i;
            addr_q <= addr_i;
        end else if (release_i) begin
            vld_q  <= 1'b0;
        end
    end

    assign vld_o  = vld_q;
    assign op_o   = op_q;
    assign addr_o = addr_q;
endmodule

// File: rtl/dbg_runctl.sv
module dbg_runctl
    import dbg_rc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [AW-1:0] fetch_addr,
    input  logic          retire,
    input  logic          retire_ebreak,
    output logic          fetch_en,
    output logic          halted,
    output logic [1:0]    halt_cause,
    output logic          core_rst
);
    localparam int OW = $bits(rc_op_e);

    rc_state_e state_q, state_d;
    rc_cause_e cause_q, cause_d;
    logic      skip_q, skip_d;
    logic      crst_q, crst_d;

    logic          stepping;
    logic          pend_vld;
    logic [OW-1:0] pend_op;
    logic [AW-1:0] pend_addr;
    logic          eff_vld;
    logic [OW-1:0] eff_op;
    logic [AW-1:0] eff_addr;
    logic          hold_cap;
    logic          hold_rel;
    logic          bp_armed;
    logic [AW-1:0] bp_addr;
    logic          bp_hit;

    assign stepping = (state_q == ST_SFETCH) || (state_q == ST_SWAIT);

    // parked command replays first once the step has ended
    assign eff_vld  = !stepping && (pend_vld || cmd_valid);
    assign eff_op   = pend_vld ? pend_op   : cmd_op;
    assign eff_addr = pend_vld ? pend_addr : cmd_addr;
    assign hold_cap = cmd_valid && (stepping || pend_vld);
    assign hold_rel = pend_vld && !stepping;

    rc_cmd_hold #(.AW(AW), .OW(OW)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (hold_cap),
        .op_i      (cmd_op),
        .addr_i    (cmd_addr),
        .release_i (hold_rel),
        .vld_o     (pend_vld),
        .op_o      (pend_op),
        .addr_o    (pend_addr)
    );

    rc_bp_unit #(.AW(AW)) u_bp (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_i        (eff_vld && (eff_op == OP_SETBP)),
        .clr_i        (eff_vld && (eff_op == OP_CLRBP)),
        .addr_i       (eff_addr),
        .fetch_addr_i (fetch_addr),
        .armed_o      (bp_armed),
        .bp_addr_o    (bp_addr),
        .hit_o        (bp_hit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
            cause_q <= HC_STOP;
            skip_q  <= 1'b0;
            crst_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
            skip_q  <= skip_d;
            crst_q  <= crst_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cause_d = cause_q;
        skip_d  = 1'b0;
        crst_d  = 1'b0;
        unique case (state_q)
            ST_HALT: begin
                if (eff_vld && (eff_op == OP_RUN)) begin
                    state_d = ST_RUN;
                    skip_d  = 1'b1;
                end else if (eff_vld && (eff_op == OP_STEP)) begin
                    state_d = ST_SFETCH;
                end else if (eff_vld && (eff_op == OP_RESET)) begin
                    cause_d = HC_STOP;
                    crst_d  = 1'b1;
                end
            end
            ST_RUN: begin
                if (eff_vld && (eff_op == OP_RESET)) begin
                    state_d = ST_HALT;
                    cause_d = HC_STOP;
                    crst_d  = 1'b1;
                end else if (retire && retire_ebreak) begin
                    state_d = ST_HALT;
                    cause_d = HC_EBREAK;
                end else if (bp_hit && !skip_q) begin
                    state_d = ST_HALT;
                    cause_d = HC_BREAK;
                end else if (eff_vld && (eff_op == OP_STOP)) begin
                    state_d = ST_HALT;
                    cause_d = HC_STOP;
                end
            end
            ST_SFETCH, ST_SWAIT: begin
                if (retire) begin
                    state_d = ST_HALT;
                    cause_d = retire_ebreak ? HC_EBREAK : HC_STEP;
                end else begin
                    state_d = ST_SWAIT;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_RUN:    fetch_en = !(bp_hit && !skip_q);
            ST_SFETCH: fetch_en = 1'b1;
            ST_HALT,
            ST_SWAIT:  fetch_en = 1'b0;
        endcase
        halted     = (state_q == ST_HALT);
        halt_cause = cause_q;
        core_rst   = crst_q;
    end
endmodule

// File: rtl/rc_checker.sv
module rc_checker
    import dbg_rc_pkg::*;
#(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [2:0]    cmd_op,
    input logic [AW-1:0] fetch_addr,
    input logic          retire,
    input logic          retire_ebreak,
    input logic          fetch_en,
    input logic          halted,
    input logic [1:0]    halt_cause,
    input logic          core_rst,
    input rc_state_e     state_q,
    input logic          skip_q,
    input logic          bp_armed,
    input logic [AW-1:0] bp_addr
);
    logic [1:0] sf_cnt;
    logic       in_step;

    assign in_step = (state_q == ST_SFETCH) || (state_q == ST_SWAIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          sf_cnt <= 2'd0;
        else if (!in_step)                   sf_cnt <= 2'd0;
        else if (fetch_en && sf_cnt != 2'd3) sf_cnt <= sf_cnt + 2'd1;
    end

    AST_HALT_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !fetch_en); // R1

    AST_BP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && bp_armed && fetch_addr == bp_addr && !skip_q) |-> !fetch_en); // R5

    AST_STEP_ONE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SWAIT) |-> (sf_cnt == 2'd1)); // R8

    AST_EBREAK_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && retire && retire_ebreak &&
         !(state_q == ST_RUN && cmd_valid && cmd_op == 3'd4))
        |=> (halted && halt_cause == 2'd3)); // R7

    AST_RST_WHEN_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |-> (halted && halt_cause == 2'd0)); // R10
endmodule

bind dbg_runctl rc_checker #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .fetch_addr    (fetch_addr),
    .retire        (retire),
    .retire_ebreak (retire_ebreak),
    .fetch_en      (fetch_en),
    .halted        (halted),
    .halt_cause    (halt_cause),
    .core_rst      (core_rst),
    .state_q       (state_q),
    .skip_q        (skip_q),
    .bp_armed      (bp_armed),
    .bp_addr       (bp_addr)
);

// File: tb/sim_dbg_runctl.sv
`timescale 1ns/1ps
module sim_dbg_runctl;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic [AW-1:0] fetch_addr = '0;
    logic          retire = 1'b0;
    logic          retire_ebreak = 1'b0;
    logic          fetch_en;
    logic          halted;
    logic [1:0]    halt_cause;
    logic          core_rst;

    int n_vec = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    dbg_runctl #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .fetch_addr(fetch_addr), .retire(retire),
        .retire_ebreak(retire_ebreak), .fetch_en(fetch_en), .halted(halted),
        .halt_cause(halt_cause), .core_rst(core_rst)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic send(input logic [2:0] op, input logic [AW-1:0] a);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
        #1;
    endtask

    task automatic pulse_ret(input logic eb);
        @(negedge clk);
        retire = 1'b1; retire_ebreak = eb;
        @(negedge clk);
        retire = 1'b0; retire_ebreak = 1'b0;
        #1;
    endtask

    task automatic t_reset_state();
        chk("R1 halted", halted, 1);
        chk("R1 fetch_en", fetch_en, 0);
        chk("R1 cause", halt_cause, 0);
        chk("R1 core_rst", core_rst, 0);
    endtask

    task automatic t_run_stop();
        fetch_addr = 32'h40;
        send(3'd1, '0);
        chk("R2 halted after run", halted, 0);
        chk("R2 fetch_en first", fetch_en, 1);
        tick(); tick(); tick();
        chk("R2 fetch_en sustained", fetch_en, 1);
        send(3'd2, '0);
        chk("R3 halted after stop", halted, 1);
        chk("R3 cause stop", halt_cause, 0);
        chk("R1 no fetch halted", fetch_en, 0);
        send(3'd2, '0);
        chk("R3 stop while halted", halted, 1);
    endtask

    task automatic t_breakpoint();
        fetch_addr = 32'h40;
        send(3'd5, 32'h100);
        send(3'd5, 32'h200);
        send(3'd1, '0);
        chk("R2 run fetch", fetch_en, 1);
        fetch_addr = 32'h100; #1;
        chk("R4 old bp no block", fetch_en, 1);
        tick();
        chk("R4 old bp no halt", halted, 0);
        fetch_addr = 32'h200; #1;
        chk("R5 fetch blocked", fetch_en, 0);
        tick();
        chk("R5 halted", halted, 1);
        chk("R5 cause break", halt_cause, 2);
    endtask

    task automatic t_resume();
        send(3'd1, '0);
        chk("R6 leave bp fetch", fetch_en, 1);
        chk("R6 leave bp running", halted, 0);
        fetch_addr = 32'h204;
        tick();
        chk("R6 still running", halted, 0);
        chk("R6 still fetching", fetch_en, 1);
        send(3'd2, '0);
        chk("R3 stop cause", halt_cause, 0);
    endtask

    task automatic t_ebreak();
        send(3'd6, '0);
        fetch_addr = 32'h200;
        send(3'd1, '0);
        tick(); tick();
        chk("R7 cleared bp no block", fetch_en, 1);
        chk("R7 cleared bp running", halted, 0);
        pulse_ret(1'b1);
        chk("R7 ebreak halted", halted, 1);
        chk("R7 ebreak cause", halt_cause, 3);
    endtask

    task automatic t_step();
        fetch_addr = 32'h300;
        send(3'd5, 32'h300);
        send(3'd3, '0);
        chk("R6 step fetch at bp", fetch_en, 1);
        chk("R8 not halted in step", halted, 0);
        tick();
        chk("R8 fetch off after one", fetch_en, 0);
        tick();
        chk("R8 still waiting", halted, 0);
        chk("R8 still no fetch", fetch_en, 0);
        pulse_ret(1'b0);
        chk("R8 halted after retire", halted, 1);
        chk("R8 cause step", halt_cause, 1);
        send(3'd6, '0);
        send(3'd3, '0);
        tick();
        pulse_ret(1'b1);
        chk("R8 step ebreak halted", halted, 1);
        chk("R8 step ebreak cause", halt_cause, 3);
    endtask

    task automatic t_hold();
        fetch_addr = 32'h400;
        send(3'd3, '0);
        send(3'd1, '0);
        chk("R9 held no run", halted, 0);
        chk("R9 held no fetch", fetch_en, 0);
        tick();
        chk("R9 held still waiting", fetch_en, 0);
        pulse_ret(1'b0);
        chk("R9 halt first", halted, 1);
        chk("R9 step cause", halt_cause, 1);
        tick();
        chk("R9 replayed run", halted, 0);
        chk("R9 replayed fetch", fetch_en, 1);
        send(3'd2, '0);
    endtask

    task automatic t_core_reset();
        send(3'd1, '0);
        chk("R10 running before", halted, 0);
        send(3'd4, '0);
        chk("R10 core_rst pulse", core_rst, 1);
        chk("R10 halted", halted, 1);
        chk("R10 cause", halt_cause, 0);
        tick();
        chk("R10 pulse ends", core_rst, 0);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset_state();
        t_run_stop();
        t_breakpoint();
        t_resume();
        t_ebreak();
        t_step();
        t_hold();
        t_core_reset();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule